// File: doc/BRIEF.md
# Programmable Path Detection Stack

The block watches the stream of retired branches and turns it into a stream of completed program paths. Each incoming record gives a branch kind (call, return, forward, backward or indirect), the taken/not-taken outcome, the target address and the number of events counted since the previous branch. The block keeps a small stack of open paths, one per active context. Each open path is a descriptor made of a start address, a branch count and one direction bit per recorded branch, plus an 8-bit saturating event counter. When a path is closed, its descriptor and event count are presented on a valid/ready output stream.

A configuration input assigns up to four actions to each branch kind: full update, count-only update, pop and push. The actions always run in that order. The same hardware can therefore close paths on loop back-edges, on calls, or on any other choice of boundary. An optional extension mode lets a path run across a set number of loop back-edges or returns before it is closed. Paths longer than the descriptor capacity are split. When the stack overflows, the oldest context is lost. A context recreated after an underflow is marked incomplete and is never emitted.

Top module: `path_trace_stack`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid` is 0 and the stack is empty, so a branch whose only action is a pop emits nothing.
- R2: An emitted descriptor gives the path's start address on `out_start` and its number of recorded branches on `out_len`. Bit i of `out_dirs` is the outcome of the i-th recorded branch, with 1 meaning taken. Bits at index `out_len` and above are 0.
- R3: A push opens a new top entry whose start is the branch target, with length, direction bits, event count and extension count all zero.
- R4: A full update adds one to the length, stores the outcome in the next direction bit and adds `in_events` to the top entry's event count. A count-only update adds `in_events` to the event count and leaves the length and direction bits unchanged.
- R5: The event count saturates at 255 and never wraps.
- R6: `cfg_action_mask[4*k +: 4]` holds the actions for kind code k, where call=0, return=1, forward=2, backward=3 and indirect=4. In each 4-bit mask, bit0 is update, bit1 is count-only, bit2 is pop and bit3 is push. If bit0 and bit1 are both set, only the full update runs. The selected actions run in the order update, pop, push. Kind codes 5 to 7 do nothing.
- R7: The intra-procedural setting works as follows. Call = 4'b1010 and return = 4'b0110, so a call opens a new path and a return emits the callee's path. Forward = 4'b0001. Backward and indirect = 4'b1101, which records the branch, emits the path and opens a path at the target.
- R8: A path holds up to 32 branches. A full update on a 32-branch path emits that path with this branch's events added and its length unchanged. The top entry is then replaced by a fresh entry starting at the branch target. Any pop or push selected for the same branch still runs afterwards.
- R9: A push on a full stack (4 entries) discards the bottom entry. An update or count-only update on an empty stack acts on a new entry marked incomplete. Incomplete entries, and pops of an empty stack, emit nothing.
- R10: When `cfg_ext_enable` is 1, a boundary branch is treated specially if the top entry's extension count is below `cfg_ext_limit`. The boundary branch is a backward branch, or a return when `cfg_ext_on_return` is 1. Such a branch only performs a full update and adds one to the extension count. Otherwise the branch's configured actions apply.
- R11: `in_ready` is 1 only while the block is idle. An accepted branch drops it until all of that branch's actions have finished. While `out_valid` is 1 and `out_ready` is 0, the output fields hold steady and the block accepts no input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_action_mask | input | 20 | Four action bits per branch kind |
| cfg_ext_enable | input | 1 | Enables path extension across boundaries |
| cfg_ext_on_return | input | 1 | Boundary is return (1) or backward branch (0) |
| cfg_ext_limit | input | 2 | Maximum number of boundaries crossed |
| in_valid | input | 1 | Branch record valid |
| in_ready | output | 1 | Block can accept a branch record |
| in_kind | input | 3 | Branch kind code |
| in_taken | input | 1 | Branch outcome, 1 = taken |
| in_target | input | 16 | Branch target address |
| in_events | input | 4 | Events since previous branch |
| out_valid | output | 1 | Descriptor valid |
| out_ready | input | 1 | Consumer accepts descriptor |
| out_start | output | 16 | Path start address |
| out_len | output | 6 | Branches on the path |
| out_dirs | output | 32 | Direction bits, bit 0 first |
| out_events | output | 8 | Saturated event count of the path |

## Verification
The assertions assume that the configuration inputs change only while the block is idle. They also assume that the extension limit is never lowered while entries opened under a higher limit are still on the stack, and that the output consumer handles the valid/ready pair in the usual way. The stimulus keeps to these limits. It changes the configuration only between complete branch records, and it sets the extension settings only under reset. The mask sweep covers every one of the sixteen action masks for each of the five kinds. It starts from a known single entry and drains the stack with pop-only branches, so every effect of a mask shows up in the emitted order and contents.

// File: rtl/pts_pkg.sv
// Package: shared constants and types for the path detection stack.
// Assumes kind codes below NUM_KINDS are the only meaningful ones.
package pts_pkg;
    localparam int NUM_KINDS = 5;
    localparam int MASK_W    = 4;

    typedef enum logic [2:0] {
        K_CALL = 3'd0,
        K_RET  = 3'd1,
        K_FWD  = 3'd2,
        K_BACK = 3'd3,
        K_IND  = 3'd4
    } pts_kind_e;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_UPD  = 3'd1,
        S_POP  = 3'd2,
        S_PUSH = 3'd3,
        S_EMIT = 3'd4
    } pts_state_e;

    typedef struct packed {
        logic upd;
        logic cnt;
        logic pop;
        logic push;
        logic ext_step;
    } pts_ops_t;
endpackage

// File: rtl/pts_sat_add.sv
// Module: saturating adder for the per-path event counter.
// Assumes the increment is no wider than the accumulator.
module pts_sat_add #(
    parameter int ACC_W = 8,
    parameter int INC_W = 4
) (
    input  logic [ACC_W-1:0] acc,
    input  logic [INC_W-1:0] inc,
    output logic [ACC_W-1:0] sum
);
    logic [ACC_W:0] wide;

    // Add with one carry bit and clamp at all ones.
    always_comb begin
        wide = {1'b0, acc} + (ACC_W+1)'(inc);
        sum  = wide[ACC_W] ? {ACC_W{1'b1}} : wide[ACC_W-1:0];
    end
endmodule

// File: rtl/pts_action_decode.sv
// Module: maps a branch kind and the configuration to the set of stack
// actions, applying the extension override for boundary branches.
// Assumes the top entry's extension count is supplied as zero when the
// stack is empty.
module pts_action_decode
    import pts_pkg::*;
#(
    parameter int EXT_W = 2
) (
    input  logic [NUM_KINDS*MASK_W-1:0] cfg_action_mask,
    input  logic                        cfg_ext_enable,
    input  logic                        cfg_ext_on_return,
    input  logic [EXT_W-1:0]            cfg_ext_limit,
    input  logic [2:0]                  kind,
    input  logic [EXT_W-1:0]            top_ext,
    output pts_ops_t                    ops
);
    logic [MASK_W-1:0] mask;
    logic              boundary;

    // Select this kind's mask and decide whether extension absorbs the branch.
    always_comb begin
        mask = '0;
        if (int'(kind) < NUM_KINDS)
            mask = cfg_action_mask[int'(kind)*MASK_W +: MASK_W];
        boundary = cfg_ext_on_return ? (kind == K_RET) : (kind == K_BACK);
        if (cfg_ext_enable && boundary && (top_ext < cfg_ext_limit)) begin
            ops = '{upd: 1'b1, cnt: 1'b0, pop: 1'b0, push: 1'b0, ext_step: 1'b1};
        end else begin
            ops.upd      = mask[0];
            ops.cnt      = mask[1] & ~mask[0];
            ops.pop      = mask[2];
            ops.push     = mask[3];
            ops.ext_step = 1'b0;
        end
    end
endmodule

// File: rtl/pts_entry_store.sv
// Module: storage for the circular path stack, one write and one read port.
// Assumes the controller owns the pointer; writes land at the clock edge and
// reads are combinational.
module pts_entry_store #(
    parameter int DEPTH   = 4,
    parameter int ADDR_W  = 16,
    parameter int MAX_LEN = 32,
    parameter int LEN_W   = 6,
    parameter int CNT_W   = 8,
    parameter int EXT_W   = 2,
    parameter int PTR_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [PTR_W-1:0]   waddr,
    input  logic [ADDR_W-1:0]  w_start,
    input  logic [LEN_W-1:0]   w_len,
    input  logic [MAX_LEN-1:0] w_dirs,
    input  logic [CNT_W-1:0]   w_evt,
    input  logic [EXT_W-1:0]   w_ext,
    input  logic               w_inc,
    input  logic [PTR_W-1:0]   raddr,
    output logic [ADDR_W-1:0]  r_start,
    output logic [LEN_W-1:0]   r_len,
    output logic [MAX_LEN-1:0] r_dirs,
    output logic [CNT_W-1:0]   r_evt,
    output logic [EXT_W-1:0]   r_ext,
    output logic               r_inc
);
    logic [ADDR_W-1:0]  m_start [DEPTH];
    logic [LEN_W-1:0]   m_len   [DEPTH];
    logic [MAX_LEN-1:0] m_dirs  [DEPTH];
    logic [CNT_W-1:0]   m_evt   [DEPTH];
    logic [EXT_W-1:0]   m_ext   [DEPTH];
    logic               m_inc   [DEPTH];

    // Clear all slots on reset, otherwise write the addressed slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                m_start[i] <= '0;
                m_len[i]   <= '0;
                m_dirs[i]  <= '0;
                m_evt[i]   <= '0;
                m_ext[i]   <= '0;
                m_inc[i]   <= 1'b0;
            end
        end else if (we) begin
            m_start[waddr] <= w_start;
            m_len[waddr]   <= w_len;
            m_dirs[waddr]  <= w_dirs;
            m_evt[waddr]   <= w_evt;
            m_ext[waddr]   <= w_ext;
            m_inc[waddr]   <= w_inc;
        end
    end

    // Present the addressed slot.
    always_comb begin
        r_start = m_start[raddr];
        r_len   = m_len[raddr];
        r_dirs  = m_dirs[raddr];
        r_evt   = m_evt[raddr];
        r_ext   = m_ext[raddr];
        r_inc   = m_inc[raddr];
    end
endmodule

// File: rtl/path_trace_stack.sv
// Module: programmable path detection stack. It takes one branch record at a
// time, then runs the selected actions in the fixed order update, pop, push,
// stalling in an emit state until each closed path is taken by the consumer.
// Assumes configuration changes only while idle and DEPTH is a power of two
// of at least 2.
module path_trace_stack
    import pts_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int MAX_LEN = 32,
    parameter int DEPTH   = 4,
    parameter int CNT_W   = 8,
    parameter int EVT_W   = 4,
    parameter int EXT_W   = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_KINDS*MASK_W-1:0] cfg_action_mask,
    input  logic                        cfg_ext_enable,
    input  logic                        cfg_ext_on_return,
    input  logic [EXT_W-1:0]            cfg_ext_limit,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [2:0]                  in_kind,
    input  logic                        in_taken,
    input  logic [ADDR_W-1:0]           in_target,
    input  logic [EVT_W-1:0]            in_events,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic [ADDR_W-1:0]           out_start,
    output logic [$clog2(MAX_LEN+1)-1:0] out_len,
    output logic [MAX_LEN-1:0]          out_dirs,
    output logic [CNT_W-1:0]            out_events
);
    localparam int LEN_W = $clog2(MAX_LEN+1);
    localparam int PTR_W = $clog2(DEPTH);
    localparam logic [PTR_W:0] FULL_CNT = (PTR_W+1)'(DEPTH);
    localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_LEN);

    pts_state_e         state, ret_state;
    logic [PTR_W-1:0]   ptr;
    logic [PTR_W:0]     fill;
    logic               r_taken;
    logic [ADDR_W-1:0]  r_target;
    logic [EVT_W-1:0]   r_evt;
    pts_ops_t           r_ops;
    pts_ops_t           dec_ops;

    logic [ADDR_W-1:0]  rd_start;
    logic [LEN_W-1:0]   rd_len;
    logic [MAX_LEN-1:0] rd_dirs;
    logic [CNT_W-1:0]   rd_evt;
    logic [EXT_W-1:0]   rd_ext;
    logic               rd_inc;

    logic               empty;
    logic [ADDR_W-1:0]  top_start;
    logic [LEN_W-1:0]   top_len;
    logic [MAX_LEN-1:0] top_dirs;
    logic [CNT_W-1:0]   top_evt;
    logic [EXT_W-1:0]   top_ext;
    logic               top_inc;
    logic [CNT_W-1:0]   evt_sum;
    logic               split;
    logic [PTR_W-1:0]   upd_slot;

    logic               we;
    logic [PTR_W-1:0]   waddr;
    logic [ADDR_W-1:0]  w_start;
    logic [LEN_W-1:0]   w_len;
    logic [MAX_LEN-1:0] w_dirs;
    logic [CNT_W-1:0]   w_evt;
    logic [EXT_W-1:0]   w_ext;
    logic               w_inc;

    pts_entry_store #(
        .DEPTH(DEPTH), .ADDR_W(ADDR_W), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W),
        .CNT_W(CNT_W), .EXT_W(EXT_W), .PTR_W(PTR_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr),
        .w_start(w_start), .w_len(w_len), .w_dirs(w_dirs), .w_evt(w_evt),
        .w_ext(w_ext), .w_inc(w_inc), .raddr(ptr),
        .r_start(rd_start), .r_len(rd_len), .r_dirs(rd_dirs), .r_evt(rd_evt),
        .r_ext(rd_ext), .r_inc(rd_inc)
    );

    pts_action_decode #(.EXT_W(EXT_W)) u_decode (
        .cfg_action_mask(cfg_action_mask), .cfg_ext_enable(cfg_ext_enable),
        .cfg_ext_on_return(cfg_ext_on_return), .cfg_ext_limit(cfg_ext_limit),
        .kind(in_kind), .top_ext(top_ext), .ops(dec_ops)
    );

    pts_sat_add #(.ACC_W(CNT_W), .INC_W(EVT_W)) u_sat (
        .acc(top_evt), .inc(r_evt), .sum(evt_sum)
    );

    // Top-of-stack view; an empty stack reads as a blank incomplete entry.
    always_comb begin
        empty     = (fill == '0);
        top_start = empty ? '0   : rd_start;
        top_len   = empty ? '0   : rd_len;
        top_dirs  = empty ? '0   : rd_dirs;
        top_evt   = empty ? '0   : rd_evt;
        top_ext   = empty ? '0   : rd_ext;
        top_inc   = empty ? 1'b1 : rd_inc;
        upd_slot  = empty ? ptr + 1'b1 : ptr;
        split     = r_ops.upd && (top_len == LEN_CAP);
    end

    // Storage write selection for the update and push steps.
    always_comb begin
        we      = 1'b0;
        waddr   = ptr;
        w_start = r_target;
        w_len   = '0;
        w_dirs  = '0;
        w_evt   = '0;
        w_ext   = '0;
        w_inc   = 1'b0;
        if (state == S_UPD && (r_ops.upd || r_ops.cnt)) begin
            we    = 1'b1;
            waddr = upd_slot;
            if (!split) begin
                w_start = top_start;
                w_len   = top_len;
                w_dirs  = top_dirs;
                w_evt   = evt_sum;
                w_ext   = top_ext;
                w_inc   = top_inc;
                if (r_ops.upd) begin
                    w_len  = top_len + 1'b1;
                    w_dirs = top_dirs | (MAX_LEN'(r_taken) << top_len);
                    w_ext  = top_ext + EXT_W'(r_ops.ext_step);
                end
            end
        end else if (state == S_PUSH && r_ops.push) begin
            we    = 1'b1;
            waddr = ptr + 1'b1;
        end
    end

    // Sequencer: accept, update, pop, push, and emit with back-pressure.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            ret_state  <= S_IDLE;
            ptr        <= '0;
            fill       <= '0;
            r_taken    <= 1'b0;
            r_target   <= '0;
            r_evt      <= '0;
            r_ops      <= '0;
            out_valid  <= 1'b0;
            out_start  <= '0;
            out_len    <= '0;
            out_dirs   <= '0;
            out_events <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (in_valid) begin
                        r_taken  <= in_taken;
                        r_target <= in_target;
                        r_evt    <= in_events;
                        r_ops    <= dec_ops;
                        state    <= S_UPD;
                    end
                end
                S_UPD: begin
                    state <= S_POP;
                    if (r_ops.upd || r_ops.cnt) begin
                        if (empty) begin
                            ptr  <= ptr + 1'b1;
                            fill <= (PTR_W+1)'(1);
                        end
                        if (split && !top_inc) begin
                            out_valid  <= 1'b1;
                            out_start  <= top_start;
                            out_len    <= top_len;
                            out_dirs   <= top_dirs;
                            out_events <= evt_sum;
                            ret_state  <= S_POP;
                            state      <= S_EMIT;
                        end
                    end
                end
                S_POP: begin
                    state <= S_PUSH;
                    if (r_ops.pop && !empty) begin
                        ptr  <= ptr - 1'b1;
                        fill <= fill - 1'b1;
                        if (!top_inc) begin
                            out_valid  <= 1'b1;
                            out_start  <= top_start;
                            out_len    <= top_len;
                            out_dirs   <= top_dirs;
                            out_events <= top_evt;
                            ret_state  <= S_PUSH;
                            state      <= S_EMIT;
                        end
                    end
                end
                S_PUSH: begin
                    state <= S_IDLE;
                    if (r_ops.push) begin
                        ptr  <= ptr + 1'b1;
                        fill <= (fill == FULL_CNT) ? FULL_CNT : fill + 1'b1;
                    end
                end
                S_EMIT: begin
                    if (out_ready) begin
                        out_valid <= 1'b0;
                        state     <= ret_state;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign in_ready = (state == S_IDLE);

    // R11: a stalled descriptor keeps every field steady.
    a_r11_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_start) &&
        $stable(out_len) && $stable(out_dirs) && $stable(out_events));

    // R11: an accepted record makes the block busy on the next cycle.
    a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> !in_ready);

    // R11: no input is taken while a descriptor is pending.
    a_r11_no_accept_pending: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R2: an emitted length never exceeds the descriptor capacity.
    a_r2_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_len <= LEN_CAP);

    // R3: the entry written by a push reads back blank and complete.
    a_r3_push_fresh: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_PUSH && r_ops.push |=>
        rd_len == '0 && rd_evt == '0 && rd_ext == '0 && !rd_inc && rd_dirs == '0);

    // R9: a push on a full stack keeps the stack full.
    a_r9_full_stays: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_PUSH && r_ops.push && fill == FULL_CNT |=> fill == FULL_CNT);
endmodule

// File: tb/path_trace_stack_bench.sv
// Bench: directed scenarios plus an exhaustive sweep of all action masks
// for every branch kind; expected descriptors are computed arithmetically.
module path_trace_stack_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] cfg_action_mask = '0;
    logic        cfg_ext_enable = 1'b0;
    logic        cfg_ext_on_return = 1'b0;
    logic [1:0]  cfg_ext_limit = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [2:0]  in_kind = '0;
    logic        in_taken = 1'b0;
    logic [15:0] in_target = '0;
    logic [3:0]  in_events = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [15:0] out_start;
    logic [5:0]  out_len;
    logic [31:0] out_dirs;
    logic [7:0]  out_events;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [63:0] got_q[$];

    localparam logic [19:0] DEF_MASK = {4'b1101, 4'b1101, 4'b0001, 4'b0110, 4'b1010};
    localparam logic [19:0] ALL_PUSH = {5{4'b1000}};
    localparam logic [19:0] ALL_POP  = {5{4'b0100}};
    localparam logic [19:0] CALLRET  = {4'b0000, 4'b0000, 4'b0000, 4'b0100, 4'b1000};

    path_trace_stack u_path_trace_stack (
        .clk(clk), .rst_n(rst_n), .cfg_action_mask(cfg_action_mask),
        .cfg_ext_enable(cfg_ext_enable), .cfg_ext_on_return(cfg_ext_on_return),
        .cfg_ext_limit(cfg_ext_limit), .in_valid(in_valid), .in_ready(in_ready),
        .in_kind(in_kind), .in_taken(in_taken), .in_target(in_target),
        .in_events(in_events), .out_valid(out_valid), .out_ready(out_ready),
        .out_start(out_start), .out_len(out_len), .out_dirs(out_dirs),
        .out_events(out_events)
    );

    always #5 clk = ~clk;

    // Record each descriptor that will be handed over at the next edge.
    always @(negedge clk)
        if (rst_n && out_valid && out_ready)
            got_q.push_back({2'b00, out_start, out_len, out_dirs, out_events});

    function automatic logic [63:0] pk(input logic [15:0] s, input int len,
                                       input logic [31:0] d, input int e);
        return {2'b00, s, 6'(len), d, 8'(e)};
    endfunction

    task automatic check_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic expect_desc(input string req, input logic [63:0] exp);
        checks++;
        if (got_q.size() == 0) begin
            failures++;
            $display("FAIL %s actual=none expected=%h", req, exp);
        end else begin
            logic [63:0] g;
            g = got_q.pop_front();
            if (g !== exp) begin
                failures++;
                $display("FAIL %s actual=%h expected=%h", req, g, exp);
            end
        end
    endtask

    task automatic expect_none(input string req);
        checks++;
        if (got_q.size() != 0) begin
            failures++;
            $display("FAIL %s actual=%0d extra descriptors expected=0", req, got_q.size());
            got_q.delete();
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        got_q.delete();
    endtask

    task automatic send(input int kind, input bit tk, input logic [15:0] tgt, input int ev);
        @(negedge clk);
        in_valid = 1'b1;
        in_kind = 3'(kind);
        in_taken = tk;
        in_target = tgt;
        in_events = 4'(ev);
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state, and a pop on the fresh stack emits nothing.
        cfg_action_mask = ALL_POP;
        do_reset();
        check_eq("R1 in_ready", 64'(in_ready), 64'd1);
        check_eq("R1 out_valid", 64'(out_valid), 64'd0);
        send(2, 1'b0, 16'h0, 0);
        settle();
        expect_none("R1 empty pop");

        // R7 R2 R4 R9: default intra-procedural setting.
        cfg_action_mask = DEF_MASK;
        do_reset();
        send(0, 1'b1, 16'h0100, 1);
        send(2, 1'b1, 16'h0, 2);
        send(2, 1'b0, 16'h0, 0);
        send(2, 1'b1, 16'h0, 3);
        send(3, 1'b1, 16'h0140, 1);
        settle();
        expect_desc("R7 backward closes path", pk(16'h0100, 4, 32'hD, 6));
        send(1, 1'b1, 16'h0, 2);
        settle();
        expect_desc("R4 count-only on return", pk(16'h0140, 0, 32'h0, 2));
        send(1, 1'b1, 16'h0, 0);
        send(1, 1'b1, 16'h0, 0);
        settle();
        expect_none("R9 incomplete entry dropped");

        // R5: saturation of the event count.
        do_reset();
        send(0, 1'b1, 16'h0200, 0);
        for (int i = 0; i < 20; i++) send(2, 1'b0, 16'h0, 15);
        send(4, 1'b1, 16'h0300, 15);
        settle();
        expect_desc("R5 saturated events", pk(16'h0200, 21, 32'h0010_0000, 255));

        // R8: 32 branches fit, the 33rd splits.
        do_reset();
        send(0, 1'b1, 16'h0400, 0);
        for (int i = 0; i < 32; i++) send(2, 1'((i % 2)), 16'h0500, 1);
        settle();
        expect_none("R8 32 branches fit");
        send(2, 1'b0, 16'h0500, 1);
        settle();
        expect_desc("R8 split emits full path", pk(16'h0400, 32, 32'hAAAA_AAAA, 33));
        send(1, 1'b0, 16'h0, 0);
        settle();
        expect_desc("R8 fresh entry at target", pk(16'h0500, 0, 32'h0, 0));

        // R9: overflow discards the bottom entries.
        cfg_action_mask = CALLRET;
        for (int n = 1; n <= 6; n++) begin
            do_reset();
            for (int k = 1; k <= n; k++) send(0, 1'b1, 16'(16 * k), 0);
            for (int k = 0; k < 6; k++) send(1, 1'b1, 16'h0, 0);
            settle();
            for (int k = n; k > n - ((n < 4) ? n : 4); k--)
                expect_desc("R9 overflow order", pk(16'(16 * k), 0, 32'h0, 0));
            expect_none("R9 nothing beyond depth");
        end

        // R6 R3 R4: every mask for every kind, from one known base entry.
        do_reset();
        for (int t = 0; t < 5; t++) begin
            for (int m = 0; m < 16; m++) begin
                logic [63:0] base_mod;
                logic [15:0] t1;
                t1 = 16'h07A0 + 16'(t);
                cfg_action_mask = ALL_PUSH;
                send(2, 1'b0, 16'h0700, 0);
                cfg_action_mask = '0;
                cfg_action_mask[t*4 +: 4] = 4'(m);
                send(t, 1'b1, t1, 3);
                cfg_action_mask = ALL_POP;
                for (int p = 0; p < 3; p++) send(2, 1'b0, 16'h0, 0);
                settle();
                if (m[0])      base_mod = pk(16'h0700, 1, 32'h1, 3);
                else if (m[1]) base_mod = pk(16'h0700, 0, 32'h0, 3);
                else           base_mod = pk(16'h0700, 0, 32'h0, 0);
                if (m[2]) expect_desc("R6 pop after update", base_mod);
                if (m[3]) expect_desc("R3 pushed entry", pk(t1, 0, 32'h0, 0));
                if (!m[2]) expect_desc("R4 base entry kept", base_mod);
                expect_none("R6 no extra output");
            end
        end

        // R10: extension across backward branches for each limit.
        cfg_action_mask = DEF_MASK;
        cfg_ext_enable = 1'b1;
        cfg_ext_on_return = 1'b0;
        for (int lim = 0; lim < 4; lim++) begin
            cfg_ext_limit = 2'(lim);
            do_reset();
            send(0, 1'b1, 16'h0800, 0);
            for (int k = 0; k < lim; k++) send(3, 1'b1, 16'h0900, 1);
            settle();
            expect_none("R10 boundaries absorbed");
            send(3, 1'b0, 16'h0900, 1);
            settle();
            expect_desc("R10 limit reached", pk(16'h0800, lim + 1, 32'((1 << lim) - 1), lim + 1));
        end

        // R10: extension across returns.
        cfg_ext_on_return = 1'b1;
        cfg_ext_limit = 2'd1;
        do_reset();
        send(0, 1'b1, 16'h0A00, 0);
        send(2, 1'b1, 16'h0, 0);
        send(1, 1'b0, 16'h0, 1);
        settle();
        expect_none("R10 return absorbed");
        send(1, 1'b0, 16'h0, 1);
        settle();
        expect_desc("R10 return after limit", pk(16'h0A00, 2, 32'h1, 2));
        cfg_ext_enable = 1'b0;
        cfg_ext_on_return = 1'b0;
        cfg_ext_limit = 2'd0;

        // R11: output back-pressure.
        do_reset();
        out_ready = 1'b0;
        send(0, 1'b1, 16'h0B00, 0);
        send(3, 1'b1, 16'h0B40, 0);
        repeat (5) @(negedge clk);
        check_eq("R11 held valid", 64'(out_valid), 64'd1);
        check_eq("R11 busy while stalled", 64'(in_ready), 64'd0);
        check_eq("R11 held data", {2'b00, out_start, out_len, out_dirs, out_events},
                 pk(16'h0B00, 1, 32'h1, 0));
        out_ready = 1'b1;
        settle();
        expect_desc("R11 delivered once", pk(16'h0B00, 1, 32'h1, 0));
        expect_none("R11 no duplicate");
        check_eq("R11 ready again", 64'(in_ready), 64'd1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule